// File: doc/BRIEF.md
# Calendar and Alarm Core for a Real-Time Clock

This block keeps the time of day and the calendar of a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. The values are held in binary internally. On the output side they are shown either as packed BCD or as plain binary, in either 24-hour or 12-hour form, as the mode inputs select. Time fields are loaded one at a time through a small write strobe, and each written byte is read in the encoding that is currently selected.

A one-second tick advances the calendar. It carries seconds into minutes, hours, day, month and year, and it applies the month lengths and the leap-year rule. The tick is taken only while the oscillator-control field holds its run code. When a tick is taken and set mode is off, the update-in-progress flag rises. A state machine then counts a short window on the 32.768 kHz tick. At the end of the window it sets the update-ended flag and compares the time against three alarm bytes. An enabled event also sets the interrupt flag.

The machine has three states. IDLE waits for a tick. UIP counts the window. END takes one cycle and posts the events. The transitions are:
- IDLE→UIP on an accepted tick with set mode off.
- UIP→END on the last counted 32.768 kHz tick.
- UIP→IDLE when set mode is raised, which abandons the window.
- END→IDLE always.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time is 00:00:00 with day of week 1, day of month 1, month 1 and year 00. In 12-hour form the hour reads 0x12 with bit 7 clear. `uip_o`, `flags_o` and `irq_o` are all zero.
- R2: A `sec_tick` advances the time only when `osc_ctl` is 3'b010. Any other value leaves every time field unchanged and does not raise `uip_o`.
- R3: An advance carries 59 s to the next minute, 59 min to the next hour, and 23 h to the next day. Day of week runs 1..7 and wraps to 1. Month 12 wraps to 1 and increments the year. Year 99 wraps to 00.
- R4: The last day of a month is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. February has 29 days when the two-digit year is divisible by 4 (00 counts as a century divisible by 400) and 28 days otherwise.
- R5: With `bin_mode`=1, every field is read and written as a plain binary value. With `bin_mode`=0 it is packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R6: With `hr24_mode`=0, the hour byte holds 1..12 in its low seven bits and bit 7 set for PM. Midnight reads as 12 AM and noon as 12 PM. With `hr24_mode`=1 it holds 0..23.
- R7: An accepted tick with `set_mode`=0 raises `uip_o` on the same edge that the time advances. `uip_o` stays high until `UIP_TICKS` (default 8) `osc_tick` pulses have been counted, plus one cycle. A `sec_tick` that arrives while `uip_o` is high is ignored.
- R8: When `uip_o` falls at the end of a window, `flags_o` bit 4 (update ended) is set. If `upd_irq_en` is 1, bit 7 (interrupt) is also set and `irq_o` goes high.
- R9: An alarm byte whose bits 7:6 are both 1 matches any value. Otherwise it must equal the displayed seconds, minutes or hours byte, including the PM bit. If `alarm_en` is 1 and all three bytes match at the end of a window, bits 5 and 7 of `flags_o` are set.
- R10: With `set_mode`=1 the time still advances on accepted ticks, but `uip_o` is not raised and no flag is set. Raising `set_mode` during a window ends it with no flag set.
- R11: `flag_clr` clears `flags_o` and `irq_o` on the next edge. An event posted on the same edge wins over the clear.
- R12: `wr_en` loads the field chosen by `wr_idx` from `wr_data`, decoded per R5 and R6. The field codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month and 6 year. Other fields are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| osc_tick | input | 1 | One-cycle pulse at 32.768 kHz |
| osc_ctl | input | 3 | Oscillator-control field; 3'b010 runs the clock |
| set_mode | input | 1 | Suppresses the update window and events |
| bin_mode | input | 1 | 1 binary, 0 packed BCD |
| hr24_mode | input | 1 | 1 24-hour form, 0 12-hour form with PM bit |
| alarm_en | input | 1 | Alarm event enable |
| upd_irq_en | input | 1 | Update-ended interrupt enable |
| alm_sec | input | 8 | Seconds alarm byte |
| alm_min | input | 8 | Minutes alarm byte |
| alm_hr | input | 8 | Hours alarm byte |
| wr_en | input | 1 | Field write strobe |
| wr_idx | input | 3 | Field code for the write |
| wr_data | input | 8 | Written byte in current encoding |
| flag_clr | input | 1 | Clears event flags |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hr_o | output | 8 | Hours |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |
| uip_o | output | 1 | Update in progress |
| flags_o | output | 8 | Bit 7 interrupt, bit 5 alarm, bit 4 update ended |
| irq_o | output | 1 | Interrupt request |

## Verification

The carry chain is exercised in four ways:
- The end of a year, which separates the carries at every field width.
- The last day of February in a leap year, a common year and year 00, which separates the leap-year rule from the plain month table.
- A 30-day month, which separates the short and long month lengths.
- A binary mid-range value, which separates the binary encoding from BCD.

The 12-hour tests cross both 11:59:59 PM and 11:59:59 AM, which exposes errors in the PM bit and in the display of 12.

The alarm is tried once with an exact seconds byte and wildcard minutes and hours bytes, and once with a seconds byte that does not match. The update window is run with set mode held high from the start, and again with set mode raised part-way through. Each of these runs is compared every clock against a behavioural reference model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UIP  = 2'd1,
        ST_END  = 2'd2
    } upd_state_t;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [4:0] hour;
        logic [2:0] wday;
        logic [4:0] mday;
        logic [3:0] mon;
        logic [6:0] year;
    } cal_t;

    localparam logic [2:0] OSC_RUN   = 3'b010;
    localparam logic [6:0] SEC_LAST  = 7'd59;
    localparam logic [6:0] MIN_LAST  = 7'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [2:0] WDAY_LAST = 3'd7;
    localparam logic [3:0] MON_LAST  = 4'd12;
    localparam logic [6:0] YEAR_LAST = 7'd99;

    function automatic logic [7:0] to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] units;
        tens  = v / 7'd10;
        units = v % 7'd10;
        return {tens[3:0], units[3:0]};
    endfunction

    function automatic logic [7:0] from_bcd(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    function automatic logic [7:0] enc_field(input logic [6:0] v, input logic bin);
        return bin ? {1'b0, v} : to_bcd(v);
    endfunction

    function automatic logic [4:0] days_in_month(input logic [3:0] mon, input logic [6:0] year);
        logic [4:0] d;
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
            4'd2:                    d = (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
            default:                 d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt
);
    logic [4:0] dim;

    always_comb begin
        dim = days_in_month(cur.mon, cur.year);
        nxt = cur;
        if (cur.sec >= SEC_LAST) begin
            nxt.sec = 7'd0;
            if (cur.min >= MIN_LAST) begin
                nxt.min = 7'd0;
                if (cur.hour >= HOUR_LAST) begin
                    nxt.hour = 5'd0;
                    nxt.wday = (cur.wday >= WDAY_LAST) ? 3'd1 : cur.wday + 3'd1;
                    if (cur.mday >= dim) begin
                        nxt.mday = 5'd1;
                        if (cur.mon >= MON_LAST) begin
                            nxt.mon  = 4'd1;
                            nxt.year = (cur.year >= YEAR_LAST) ? 7'd0 : cur.year + 7'd1;
                        end else begin
                            nxt.mon = cur.mon + 4'd1;
                        end
                    end else begin
                        nxt.mday = cur.mday + 5'd1;
                    end
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.min = cur.min + 7'd1;
            end
        end else begin
            nxt.sec = cur.sec + 7'd1;
        end
    end
endmodule

// File: rtl/rtc_cal_codec.sv
module rtc_cal_codec
    import rtc_cal_pkg::*;
(
    input  cal_t       cur,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    output logic [7:0] sec_b,
    output logic [7:0] min_b,
    output logic [7:0] hr_b,
    output logic [7:0] wday_b,
    output logic [7:0] mday_b,
    output logic [7:0] mon_b,
    output logic [7:0] year_b
);
    logic [6:0] h12;

    always_comb begin
        sec_b  = enc_field(cur.sec, bin_mode);
        min_b  = enc_field(cur.min, bin_mode);
        wday_b = enc_field({4'd0, cur.wday}, bin_mode);
        mday_b = enc_field({2'd0, cur.mday}, bin_mode);
        mon_b  = enc_field({3'd0, cur.mon}, bin_mode);
        year_b = enc_field(cur.year, bin_mode);
        if (cur.hour == 5'd0)
            h12 = 7'd12;
        else if (cur.hour > 5'd12)
            h12 = {2'd0, cur.hour} - 7'd12;
        else
            h12 = {2'd0, cur.hour};
        if (hr24_mode)
            hr_b = enc_field({2'd0, cur.hour}, bin_mode);
        else
            hr_b = enc_field(h12, bin_mode) | ((cur.hour >= 5'd12) ? 8'h80 : 8'h00);
    end
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm #(
    parameter int N_ALM = 3
) (
    input  logic [N_ALM-1:0][7:0] alm_b,
    input  logic [N_ALM-1:0][7:0] now_b,
    output logic                  hit
);
    logic [N_ALM-1:0] match;

    for (genvar i = 0; i < N_ALM; i++) begin : g_cmp
        assign match[i] = (alm_b[i][7:6] == 2'b11) || (alm_b[i] == now_b[i]);
    end

    assign hit = &match;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int UIP_TICKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       osc_tick,
    input  logic [2:0] osc_ctl,
    input  logic       set_mode,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic       alarm_en,
    input  logic       upd_irq_en,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hr,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic       flag_clr,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hr_o,
    output logic [7:0] wday_o,
    output logic [7:0] mday_o,
    output logic [7:0] mon_o,
    output logic [7:0] year_o,
    output logic       uip_o,
    output logic [7:0] flags_o,
    output logic       irq_o
);
    localparam int         CW      = $clog2(UIP_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(UIP_TICKS - 1);
    localparam cal_t       CAL_RST = '{sec: 7'd0, min: 7'd0, hour: 5'd0, wday: 3'd1,
                                       mday: 5'd1, mon: 4'd1, year: 7'd0};

    upd_state_t    st_q, st_d;
    logic [CW-1:0] cnt_q;
    cal_t          cal_q, cal_d, cal_step;
    logic          sec_go, end_ok, alm_hit;
    logic          uip_q, uf_q, af_q, irqf_q;
    logic [7:0]    wr_val, hr_raw, hr_val;

    rtc_cal_step u_step (
        .cur (cal_q),
        .nxt (cal_step)
    );

    rtc_cal_codec u_codec (
        .cur       (cal_q),
        .bin_mode  (bin_mode),
        .hr24_mode (hr24_mode),
        .sec_b     (sec_o),
        .min_b     (min_o),
        .hr_b      (hr_o),
        .wday_b    (wday_o),
        .mday_b    (mday_o),
        .mon_b     (mon_o),
        .year_b    (year_o)
    );

    rtc_cal_alarm #(.N_ALM(3)) u_alarm (
        .alm_b ({alm_hr, alm_min, alm_sec}),
        .now_b ({hr_o, min_o, sec_o}),
        .hit   (alm_hit)
    );

    assign sec_go = (st_q == ST_IDLE) && sec_tick && (osc_ctl == OSC_RUN);
    assign end_ok = (st_q == ST_END) && !set_mode;

    // Write decoding in the currently selected encoding
    always_comb begin
        wr_val = bin_mode ? wr_data : from_bcd(wr_data);
        hr_raw = bin_mode ? {1'b0, wr_data[6:0]} : from_bcd({1'b0, wr_data[6:0]});
        if (hr24_mode)
            hr_val = hr_raw;
        else
            hr_val = ((hr_raw == 8'd12) ? 8'd0 : hr_raw) + (wr_data[7] ? 8'd12 : 8'd0);
    end

    // Next calendar value: advance first, then a write overrides its field
    always_comb begin
        cal_d = sec_go ? cal_step : cal_q;
        if (wr_en) begin
            unique case (wr_idx)
                3'd0:    cal_d.sec  = wr_val[6:0];
                3'd1:    cal_d.min  = wr_val[6:0];
                3'd2:    cal_d.hour = hr_val[4:0];
                3'd3:    cal_d.wday = wr_val[2:0];
                3'd4:    cal_d.mday = wr_val[4:0];
                3'd5:    cal_d.mon  = wr_val[3:0];
                3'd6:    cal_d.year = wr_val[6:0];
                default: cal_d = cal_d;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= CAL_RST;
        else        cal_q <= cal_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (sec_go && !set_mode) st_d = ST_UIP;
            ST_UIP: begin
                if (set_mode)                          st_d = ST_IDLE;
                else if (osc_tick && cnt_q == CNT_LAST) st_d = ST_END;
            end
            ST_END:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register and window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_d != ST_UIP)  cnt_q <= '0;
            else if (osc_tick && st_q == ST_UIP) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output process: update flag and event flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uip_q  <= 1'b0;
            uf_q   <= 1'b0;
            af_q   <= 1'b0;
            irqf_q <= 1'b0;
        end else begin
            uip_q <= (st_d != ST_IDLE);
            if (flag_clr) begin
                uf_q   <= 1'b0;
                af_q   <= 1'b0;
                irqf_q <= 1'b0;
            end
            if (end_ok) begin
                uf_q <= 1'b1;
                if (upd_irq_en) irqf_q <= 1'b1;
                if (alarm_en && alm_hit) begin
                    af_q   <= 1'b1;
                    irqf_q <= 1'b1;
                end
            end
        end
    end

    assign uip_o   = uip_q;
    assign flags_o = {irqf_q, 1'b0, af_q, uf_q, 4'b0000};
    assign irq_o   = irqf_q;

    p_hold_osc_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_ctl != OSC_RUN && !wr_en) |=> $stable(cal_q));

    p_uip_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip_o) |-> $past(sec_tick && osc_ctl == OSC_RUN && !set_mode));

    p_uf_from_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_q) |-> $past(st_q == ST_END));

    p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(upd_irq_en || alarm_en));

    p_set_no_uip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && !uip_o) |=> !uip_o);

    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && st_q != ST_END) |=> (flags_o == 8'h00 && !irq_o));

endmodule

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, sec_tick, osc_tick, set_mode, bin_mode, hr24_mode;
    logic       alarm_en, upd_irq_en, wr_en, flag_clr, uip_o, irq_o;
    logic [2:0] osc_ctl, wr_idx;
    logic [7:0] alm_sec, alm_min, alm_hr, wr_data, flags_o;
    logic [7:0] sec_o, min_o, hr_o, wday_o, mday_o, mon_o, year_o;

    rtc_calendar_core u_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .osc_tick(osc_tick),
        .osc_ctl(osc_ctl), .set_mode(set_mode), .bin_mode(bin_mode),
        .hr24_mode(hr24_mode), .alarm_en(alarm_en), .upd_irq_en(upd_irq_en),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .flag_clr(flag_clr),
        .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o),
        .uip_o(uip_o), .flags_o(flags_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit run_cmp = 0;
    bit done = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int ms, mm, mh, mw, md, mmo, my, phase, cnt, uf, af, irqf;

    function automatic int enc(int v);
        return bin_mode ? v : (v / 10) * 16 + v % 10;
    endfunction
    function automatic int enc_hr(int h);
        int h12;
        if (hr24_mode) return enc(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12) + ((h >= 12) ? 128 : 0);
    endfunction
    function automatic int dec(int b);
        return bin_mode ? b : (b / 16) * 10 + b % 16;
    endfunction
    function automatic int dim(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic bit amatch(int a, int v);
        return ((a & 'hC0) == 'hC0) || (a == v);
    endfunction

    task automatic model_second();
        ms++;
        if (ms == 60) begin ms = 0; mm++; end
        if (mm == 60) begin mm = 0; mh++; end
        if (mh == 24) begin
            mh = 0; mw = (mw == 7) ? 1 : mw + 1; md++;
            if (md > dim(mmo, my)) begin md = 1; mmo++; end
            if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mm = 0; mh = 0; mw = 1; md = 1; mmo = 1; my = 0;
            phase = 0; cnt = 0; uf = 0; af = 0; irqf = 0;
        end else begin
            bit adv, post, hit;
            adv = (phase == 0) && sec_tick && (osc_ctl == 3'b010);
            post = 0;
            hit = amatch(alm_sec, enc(ms)) && amatch(alm_min, enc(mm)) && amatch(alm_hr, enc_hr(mh));
            if (phase == 2) begin post = !set_mode; phase = 0; end
            else if (phase == 1) begin
                if (set_mode) phase = 0;
                else if (osc_tick) begin cnt++; if (cnt == 8) phase = 2; end
            end else if (adv && !set_mode) begin phase = 1; cnt = 0; end
            if (adv) model_second();
            if (wr_en) begin
                case (wr_idx)
                    0: ms = dec(wr_data);
                    1: mm = dec(wr_data);
                    2: mh = hr24_mode ? dec(wr_data & 127)
                                      : dec(wr_data & 127) % 12 + ((wr_data & 128) ? 12 : 0);
                    3: mw = dec(wr_data);
                    4: md = dec(wr_data);
                    5: mmo = dec(wr_data);
                    6: my = dec(wr_data);
                    default: ;
                endcase
            end
            if (flag_clr) begin uf = 0; af = 0; irqf = 0; end
            if (post) begin
                uf = 1;
                if (upd_irq_en) irqf = 1;
                if (alarm_en && hit) begin af = 1; irqf = 1; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R3 sec", sec_o, enc(ms));
            chk("R3 min", min_o, enc(mm));
            chk("R6 hour", hr_o, enc_hr(mh));
            chk("R3 wday", wday_o, enc(mw));
            chk("R4 mday", mday_o, enc(md));
            chk("R4 month", mon_o, enc(mmo));
            chk("R3 year", year_o, enc(my));
            chk("R7 uip", uip_o, (phase != 0) ? 1 : 0);
            chk("R8 flags", flags_o, irqf * 128 + af * 32 + uf * 16);
            chk("R11 irq", irq_o, irqf);
        end
    end

    initial begin
        osc_tick = 0;
        forever begin
            repeat (3) @(negedge clk);
            osc_tick = 1;
            @(negedge clk);
            osc_tick = 0;
        end
    end

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 0;
    endtask
    task automatic set_time(int y, int mo, int d, int w, int h, int mi, int s);
        wr(6, y); wr(5, mo); wr(4, d); wr(3, w); wr(2, h); wr(1, mi); wr(0, s);
    endtask
    task automatic pulse_tick();
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
    endtask
    task automatic second();
        pulse_tick();
        repeat (45) @(negedge clk);
    endtask
    task automatic clear_flags();
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sec_tick = 0; osc_ctl = 3'b010; set_mode = 0; bin_mode = 0;
        hr24_mode = 1; alarm_en = 0; upd_irq_en = 0; alm_sec = 0; alm_min = 0;
        alm_hr = 0; wr_en = 0; wr_idx = 0; wr_data = 0; flag_clr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sec", sec_o, 'h00); chk("R1 hour", hr_o, 'h00);
        chk("R1 wday", wday_o, 1);  chk("R1 mday", mday_o, 1);
        chk("R1 month", mon_o, 1);  chk("R1 year", year_o, 0);
        chk("R1 uip", uip_o, 0);    chk("R1 flags", flags_o, 0); chk("R1 irq", irq_o, 0);
        hr24_mode = 0; #1;
        chk("R1 hour12", hr_o, 'h12);
        hr24_mode = 1;
        run_cmp = 1;

        // R3: full carry chain
        set_time('h99, 'h12, 'h31, 7, 'h23, 'h59, 'h59);
        second();
        chk("R3 sec wrap", sec_o, 0); chk("R3 min wrap", min_o, 0);
        chk("R3 hour wrap", hr_o, 0); chk("R3 wday wrap", wday_o, 1);
        chk("R3 mday wrap", mday_o, 1); chk("R3 month wrap", mon_o, 1);
        chk("R3 year wrap", year_o, 0);

        // R4: month lengths and leap rule
        set_time('h04, 'h02, 'h28, 2, 'h23, 'h59, 'h59); second();
        chk("R4 leap 04", mday_o, 'h29); chk("R4 leap month", mon_o, 'h02);
        set_time('h01, 'h02, 'h28, 2, 'h23, 'h59, 'h59); second();
        chk("R4 common 01", mday_o, 'h01); chk("R4 common month", mon_o, 'h03);
        set_time('h00, 'h02, 'h28, 2, 'h23, 'h59, 'h59); second();
        chk("R4 century 00", mday_o, 'h29);
        set_time('h10, 'h04, 'h30, 2, 'h23, 'h59, 'h59); second();
        chk("R4 april", mday_o, 'h01); chk("R4 april month", mon_o, 'h05);

        // R5 and R12: binary encoding
        bin_mode = 1;
        set_time(99, 12, 31, 3, 23, 59, 59); second();
        chk("R5 bin year", year_o, 0); chk("R5 bin wday", wday_o, 4);
        wr(0, 45); second();
        chk("R5 bin sec", sec_o, 46); chk("R12 min untouched", min_o, 0);
        bin_mode = 0; #1;
        chk("R5 bcd view", sec_o, 'h46);

        // R6: 12-hour form
        hr24_mode = 0;
        set_time('h20, 'h06, 'h10, 1, 'h91, 'h59, 'h59); second();
        chk("R6 midnight", hr_o, 'h12); chk("R6 next day", mday_o, 'h11);
        wr(2, 'h11); wr(1, 'h59); wr(0, 'h59); second();
        chk("R6 noon", hr_o, 'h92);
        hr24_mode = 1;

        // R2: oscillator field gates the advance
        osc_ctl = 3'b110;
        wr(0, 'h30); pulse_tick();
        chk("R2 no uip", uip_o, 0);
        repeat (45) @(negedge clk);
        chk("R2 hold", sec_o, 'h30);
        osc_ctl = 3'b010;

        // R7, R8: update window and update-ended event
        clear_flags();
        pulse_tick();
        chk("R7 uip high", uip_o, 1);
        repeat (45) @(negedge clk);
        chk("R7 uip low", uip_o, 0); chk("R8 uf only", flags_o, 'h10); chk("R8 no irq", irq_o, 0);
        upd_irq_en = 1; clear_flags(); second();
        chk("R8 uf irq", flags_o, 'h90); chk("R8 irq pin", irq_o, 1);
        upd_irq_en = 0;

        // R11: clear
        clear_flags();
        chk("R11 cleared", flags_o, 0); chk("R11 irq low", irq_o, 0);

        // R9: alarm with wildcards
        alarm_en = 1; alm_min = 'hC0; alm_hr = 'hFF; alm_sec = 'h05;
        wr(0, 'h04); second();
        chk("R9 alarm hit", flags_o, 'hB0);
        clear_flags(); alm_sec = 'h09; second();
        chk("R9 alarm miss", flags_o, 'h10);
        alarm_en = 0; clear_flags();

        // R10: set mode
        set_mode = 1; wr(0, 'h10); pulse_tick();
        chk("R10 no uip", uip_o, 0);
        repeat (45) @(negedge clk);
        chk("R10 advanced", sec_o, 'h11); chk("R10 no flags", flags_o, 0);
        set_mode = 0; pulse_tick();
        repeat (6) @(negedge clk);
        set_mode = 1;
        repeat (40) @(negedge clk);
        chk("R10 abort uip", uip_o, 0); chk("R10 abort flags", flags_o, 0);
        set_mode = 0;
        repeat (5) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule